// File: doc/BRIEF.md
# Accelerator Control and Status Register Bank

This block is the register front end of a packet-processing accelerator. A host reaches it over an AXI4-Lite slave port inside a 4 KiB window that sits at offset 0x10000 of the accelerator's address space. Through it the host starts and cancels a processing run, reads the engine's idle flag and its sticky error bits, and programs the run configuration. The configuration covers the device MAC and IPv4 address, the number of detector modules, the collection mode, the expected frame count and the on-card summation factor. These values leave the block on plain output ports.

The block also keeps seven 64-bit event counters, each fed by a one-cycle pulse input. Three of them describe the current run: the stall count before the host-memory write, the stall count before the high-bandwidth memory access, and the count of packets the action processed. A run start zeroes these three. The other four count valid Ethernet, ICMP, UDP and detector packets. They survive a run start and are zeroed only by reset or by the counter-clear bit. The module-count and summation fields are stored as the value minus one.

All registers are 32-bit and are written as whole words. Offsets below are relative to the window base.

Top module: `accel_csr`

## Requirements
- R1: A write is accepted when address and data are both valid and no write response is pending. A read is accepted when no read response is pending. Each accepted access gets exactly one response, and that response is held until it is taken. The write response and the read response are always OKAY (0).
- R2: The control word sits at 0x00. Bit 0 reads back the last written start value. Writing 1 to bit 0 raises `actStart` for exactly one cycle, starting in the cycle after the write is accepted. Bit 1 reads the `idleIn` input. Bit 2 is cancel and bit 3 is counter-clear; both are driven out on `actCancel` and `clrNetCnt`. Both are zero after reset, and both are forced to zero by any write that sets bit 0.
- R3: Control bits 27:24 latch pulses on `errIn[3:0]`. Each bit stays set until reset or a start write. When an error pulse and a start write fall in the same cycle, the start write wins.
- R4: Counters 0 to 2 are zeroed by reset or a start write. Counter 0 is the host-write stall count, counter 1 is the memory stall count and counter 2 is the action packet count. Each counter adds one for every cycle its `evtIn` bit is high.
- R5: Counters 3 to 6 count Ethernet, ICMP, UDP and detector packets, from `evtIn[3]` to `evtIn[6]`. A start write leaves them unchanged. They are zeroed by reset, or by a control write with bit 3 set and bit 0 clear, in the cycle of that write.
- R6: Counter k reads its low word at 0x10+8k and its high word at 0x14+8k. A high-word read returns the upper half as captured by the most recent low-word read of the same counter.
- R7: The module-count field at 0x8C and the summation field at 0x98 hold the value minus one. `cfgModules` and `cfgSummation` output the stored value plus one, so a stored 0 gives 1.
- R8: The mode register at 0x90 keeps bit 0 (photon conversion, output `cfgPhotonConv`) and bits 31:16 (collection ID, output `cfgCollId`). All other bits read as zero.
- R9: The registers below read back what was written and drive their outputs directly: MAC low word at 0x80, MAC high word at 0x84, IPv4 address at 0x88 and frame count at 0x94. All values are in network byte order as given by the host.
- R10: A write to a read-only offset, to an unmapped offset, or outside the window changes nothing. Reads of unmapped offsets and reads outside the window return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| axiAwValid | input | 1 | Write address valid |
| axiAwReady | output | 1 | Write address ready |
| axiAwAddr | input | ADDR_W | Write address |
| axiWValid | input | 1 | Write data valid |
| axiWReady | output | 1 | Write data ready |
| axiWData | input | 32 | Write data |
| axiBValid | output | 1 | Write response valid |
| axiBReady | input | 1 | Write response ready |
| axiBResp | output | 2 | Write response code |
| axiArValid | input | 1 | Read address valid |
| axiArReady | output | 1 | Read address ready |
| axiArAddr | input | ADDR_W | Read address |
| axiRValid | output | 1 | Read data valid |
| axiRReady | input | 1 | Read data ready |
| axiRData | output | 32 | Read data |
| axiRResp | output | 2 | Read response code |
| idleIn | input | 1 | Engine idle flag |
| evtIn | input | 7 | Event pulses, one per counter |
| errIn | input | 4 | Host writer error pulses |
| actStart | output | 1 | One-cycle run start pulse |
| actCancel | output | 1 | Cancel request level |
| clrNetCnt | output | 1 | Stored counter-clear bit |
| cfgMac | output | 64 | MAC address slot |
| cfgIpv4 | output | 32 | IPv4 address |
| cfgModules | output | 32 | Module count (stored + 1) |
| cfgFrames | output | 32 | Expected frame count |
| cfgSummation | output | 32 | Summation factor (stored + 1) |
| cfgPhotonConv | output | 1 | Photon conversion enable |
| cfgCollId | output | 16 | Collection identifier |

## Verification
Most faults in this block show up on the very next read. A counter that starts from the wrong value, or that clears under the wrong rule, gives a wrong low word as soon as it is read after a run start or a counter-clear write. A stuck cancel or error bit shows up on the next control-word read, and on `actCancel` in the cycle after the write. A wrong minus-one decode shows up on `cfgModules` or `cfgSummation` one cycle after the write is accepted. A broken handshake state shows up as a lost or doubled response on the next access.

// File: rtl/accel_csr_pkg.sv
package accel_csr_pkg;
  localparam int OFF_W = 12;
  localparam int WORD_W = OFF_W - 2;
  localparam int NUM_CNT = 7;
  localparam int NUM_START_CNT = 3;
  localparam int CNT_W = 64;
  localparam int ERR_W = 4;

  localparam logic [WORD_W-1:0] W_CTRL   = WORD_W'(0);
  localparam logic [WORD_W-1:0] W_CNT0   = WORD_W'(4);
  localparam logic [WORD_W-1:0] W_MAC_LO = WORD_W'(32);
  localparam logic [WORD_W-1:0] W_MAC_HI = WORD_W'(33);
  localparam logic [WORD_W-1:0] W_IPV4   = WORD_W'(34);
  localparam logic [WORD_W-1:0] W_MODS   = WORD_W'(35);
  localparam logic [WORD_W-1:0] W_MODE   = WORD_W'(36);
  localparam logic [WORD_W-1:0] W_FRAMES = WORD_W'(37);
  localparam logic [WORD_W-1:0] W_SUM    = WORD_W'(38);

  typedef struct packed {
    logic             wrEn;
    logic [OFF_W-1:0] wrOff;
    logic [31:0]      wrData;
    logic             rdEn;
    logic [OFF_W-1:0] rdOff;
  } strobes_t;
endpackage

// File: rtl/accel_csr_ctrl.sv
module accel_csr_ctrl
  import accel_csr_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter logic [ADDR_W-1:0] BASE = ADDR_W'('h10000)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              awValid,
  input  logic [ADDR_W-1:0] awAddr,
  input  logic              wValid,
  input  logic [31:0]       wData,
  output logic              awReady,
  output logic              wReady,
  output logic              bValid,
  input  logic              bReady,
  input  logic              arValid,
  input  logic [ADDR_W-1:0] arAddr,
  output logic              arReady,
  output logic              rValid,
  input  logic              rReady,
  output logic [31:0]       rData,
  input  logic [31:0]       dpRdData,
  output strobes_t          strb
);
  logic bValidQ, rValidQ;
  logic [31:0] rDataQ;
  logic wrAcc, rdAcc, wrHit, rdHit;

  assign wrAcc = awValid && wValid && !bValidQ;
  assign rdAcc = arValid && !rValidQ;
  assign wrHit = awAddr[ADDR_W-1:OFF_W] == BASE[ADDR_W-1:OFF_W];
  assign rdHit = arAddr[ADDR_W-1:OFF_W] == BASE[ADDR_W-1:OFF_W];

  assign awReady = !bValidQ;
  assign wReady  = !bValidQ;
  assign arReady = !rValidQ;
  assign bValid  = bValidQ;
  assign rValid  = rValidQ;
  assign rData   = rDataQ;

  always_comb begin
    strb.wrEn   = wrAcc && wrHit;
    strb.wrOff  = awAddr[OFF_W-1:0];
    strb.wrData = wData;
    strb.rdEn   = rdAcc && rdHit;
    strb.rdOff  = arAddr[OFF_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bValidQ <= 1'b0;
      rValidQ <= 1'b0;
      rDataQ  <= '0;
    end else begin
      if (wrAcc) bValidQ <= 1'b1;
      else if (bReady) bValidQ <= 1'b0;
      if (rdAcc) begin
        rValidQ <= 1'b1;
        rDataQ  <= rdHit ? dpRdData : 32'd0;
      end else if (rReady) begin
        rValidQ <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/accel_csr_dp.sv
module accel_csr_dp
  import accel_csr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           strb,
  input  logic               idleIn,
  input  logic [NUM_CNT-1:0] evtIn,
  input  logic [ERR_W-1:0]   errIn,
  output logic [31:0]        rdData,
  output logic               actStart,
  output logic               actCancel,
  output logic               clrNetCnt,
  output logic [63:0]        cfgMac,
  output logic [31:0]        cfgIpv4,
  output logic [31:0]        cfgModules,
  output logic [31:0]        cfgFrames,
  output logic [31:0]        cfgSummation,
  output logic               cfgPhotonConv,
  output logic [15:0]        cfgCollId
);
  logic [WORD_W-1:0] wrWord, rdWord;
  logic ctrlWr, startPulse, netClrPulse;
  logic startBitQ, startQ, cancelQ, clrNetQ;
  logic [ERR_W-1:0] errQ;
  logic [31:0] macLoQ, macHiQ, ipQ, modsQ, framesQ, sumQ;
  logic photonQ;
  logic [15:0] collIdQ;
  logic [NUM_CNT-1:0][CNT_W-1:0] cntVec;
  logic [NUM_CNT-1:0][31:0] snapVec;

  assign wrWord      = strb.wrOff[OFF_W-1:2];
  assign rdWord      = strb.rdOff[OFF_W-1:2];
  assign ctrlWr      = strb.wrEn && (wrWord == W_CTRL);
  assign startPulse  = ctrlWr && strb.wrData[0];
  assign netClrPulse = ctrlWr && strb.wrData[3] && !strb.wrData[0];

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    localparam logic [WORD_W-1:0] LO_WORD = WORD_W'(int'(W_CNT0) + 2 * k);
    logic [CNT_W-1:0] cntQ;
    logic [31:0] snapQ;
    logic clrNow;
    if (k < NUM_START_CNT) begin : g_run
      assign clrNow = startPulse;
    end else begin : g_net
      assign clrNow = netClrPulse;
    end
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntQ  <= '0;
        snapQ <= '0;
      end else begin
        if (clrNow) cntQ <= '0;
        else if (evtIn[k]) cntQ <= cntQ + 1'b1;
        if (strb.rdEn && rdWord == LO_WORD) snapQ <= cntQ[CNT_W-1:32];
      end
    end
    assign cntVec[k]  = cntQ;
    assign snapVec[k] = snapQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startBitQ <= 1'b0; startQ <= 1'b0; cancelQ <= 1'b0; clrNetQ <= 1'b0;
      errQ <= '0;
      macLoQ <= '0; macHiQ <= '0; ipQ <= '0; modsQ <= '0;
      framesQ <= '0; sumQ <= '0; photonQ <= 1'b0; collIdQ <= '0;
    end else begin
      startQ <= startPulse;
      errQ   <= startPulse ? '0 : (errQ | errIn);
      if (ctrlWr) begin
        startBitQ <= strb.wrData[0];
        cancelQ   <= strb.wrData[2] && !strb.wrData[0];
        clrNetQ   <= strb.wrData[3] && !strb.wrData[0];
      end
      if (strb.wrEn) begin
        case (wrWord)
          W_MAC_LO: macLoQ  <= strb.wrData;
          W_MAC_HI: macHiQ  <= strb.wrData;
          W_IPV4:   ipQ     <= strb.wrData;
          W_MODS:   modsQ   <= strb.wrData;
          W_FRAMES: framesQ <= strb.wrData;
          W_SUM:    sumQ    <= strb.wrData;
          W_MODE: begin
            photonQ <= strb.wrData[0];
            collIdQ <= strb.wrData[31:16];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdData = '0;
    case (rdWord)
      W_CTRL: begin
        rdData[0]     = startBitQ;
        rdData[1]     = idleIn;
        rdData[2]     = cancelQ;
        rdData[3]     = clrNetQ;
        rdData[27:24] = errQ;
      end
      W_MAC_LO: rdData = macLoQ;
      W_MAC_HI: rdData = macHiQ;
      W_IPV4:   rdData = ipQ;
      W_MODS:   rdData = modsQ;
      W_FRAMES: rdData = framesQ;
      W_SUM:    rdData = sumQ;
      W_MODE:   rdData = {collIdQ, 15'd0, photonQ};
      default: ;
    endcase
    for (int k = 0; k < NUM_CNT; k++) begin
      if (rdWord == WORD_W'(int'(W_CNT0) + 2 * k))     rdData = cntVec[k][31:0];
      if (rdWord == WORD_W'(int'(W_CNT0) + 2 * k + 1)) rdData = snapVec[k];
    end
  end

  assign actStart      = startQ;
  assign actCancel     = cancelQ;
  assign clrNetCnt     = clrNetQ;
  assign cfgMac        = {macHiQ, macLoQ};
  assign cfgIpv4       = ipQ;
  assign cfgModules    = modsQ + 32'd1;
  assign cfgFrames     = framesQ;
  assign cfgSummation  = sumQ + 32'd1;
  assign cfgPhotonConv = photonQ;
  assign cfgCollId     = collIdQ;
endmodule

// File: rtl/accel_csr.sv
module accel_csr
  import accel_csr_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter logic [ADDR_W-1:0] BASE = ADDR_W'('h10000)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              axiAwValid,
  output logic              axiAwReady,
  input  logic [ADDR_W-1:0] axiAwAddr,
  input  logic              axiWValid,
  output logic              axiWReady,
  input  logic [31:0]       axiWData,
  output logic              axiBValid,
  input  logic              axiBReady,
  output logic [1:0]        axiBResp,
  input  logic              axiArValid,
  output logic              axiArReady,
  input  logic [ADDR_W-1:0] axiArAddr,
  output logic              axiRValid,
  input  logic              axiRReady,
  output logic [31:0]       axiRData,
  output logic [1:0]        axiRResp,
  input  logic              idleIn,
  input  logic [6:0]        evtIn,
  input  logic [3:0]        errIn,
  output logic              actStart,
  output logic              actCancel,
  output logic              clrNetCnt,
  output logic [63:0]       cfgMac,
  output logic [31:0]       cfgIpv4,
  output logic [31:0]       cfgModules,
  output logic [31:0]       cfgFrames,
  output logic [31:0]       cfgSummation,
  output logic              cfgPhotonConv,
  output logic [15:0]       cfgCollId
);
  strobes_t strb;
  logic [31:0] dpRdData;

  assign axiBResp = 2'b00;
  assign axiRResp = 2'b00;

  accel_csr_ctrl #(.ADDR_W(ADDR_W), .BASE(BASE)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .awValid(axiAwValid), .awAddr(axiAwAddr), .wValid(axiWValid), .wData(axiWData),
    .awReady(axiAwReady), .wReady(axiWReady), .bValid(axiBValid), .bReady(axiBReady),
    .arValid(axiArValid), .arAddr(axiArAddr), .arReady(axiArReady),
    .rValid(axiRValid), .rReady(axiRReady), .rData(axiRData),
    .dpRdData(dpRdData), .strb(strb)
  );

  accel_csr_dp dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .idleIn(idleIn), .evtIn(evtIn), .errIn(errIn),
    .rdData(dpRdData), .actStart(actStart), .actCancel(actCancel), .clrNetCnt(clrNetCnt),
    .cfgMac(cfgMac), .cfgIpv4(cfgIpv4), .cfgModules(cfgModules), .cfgFrames(cfgFrames),
    .cfgSummation(cfgSummation), .cfgPhotonConv(cfgPhotonConv), .cfgCollId(cfgCollId)
  );
endmodule

// File: rtl/accel_csr_chk.sv
module accel_csr_chk (
  input logic        clk,
  input logic        rstN,
  input logic        bValid,
  input logic        bReady,
  input logic [1:0]  bResp,
  input logic        rValid,
  input logic        rReady,
  input logic [31:0] rData,
  input logic        actStart,
  input logic        actCancel,
  input logic        clrNet,
  input logic [3:0]  errBits
);
  AST_BRESP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    bValid && !bReady |=> bValid); // R1
  AST_RRESP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    rValid && !rReady |=> rValid && $stable(rData)); // R1
  AST_BRESP_OKAY: assert property (@(posedge clk) disable iff (!rstN)
    bValid |-> bResp == 2'b00); // R1
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    actStart |-> !actCancel && !clrNet); // R2
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    actStart |=> !actStart); // R2
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !actStart |-> ((errBits & $past(errBits)) == $past(errBits))); // R3
endmodule

bind accel_csr accel_csr_chk chk_i (
  .clk(clk), .rstN(rstN), .bValid(axiBValid), .bReady(axiBReady), .bResp(axiBResp),
  .rValid(axiRValid), .rReady(axiRReady), .rData(axiRData),
  .actStart(actStart), .actCancel(actCancel), .clrNet(clrNetCnt), .errBits(dp_i.errQ)
);

// File: tb/accel_csr_tb.sv
module accel_csr_tb_top;
  localparam int ADDR_W = 20;
  localparam logic [ADDR_W-1:0] BASE = 20'h10000;

  logic clk = 1'b0, rstN = 1'b0;
  logic awValid = 0, wValid = 0, bReady = 1, arValid = 0, rReady = 1;
  logic [ADDR_W-1:0] awAddr = '0, arAddr = '0;
  logic [31:0] wData = '0;
  logic awReady, wReady, bValid, arReady, rValid;
  logic [1:0] bResp, rResp;
  logic [31:0] rData;
  logic idleIn = 1'b1;
  logic [6:0] evtIn = '0;
  logic [3:0] errIn = '0;
  logic actStart, actCancel, clrNetCnt, cfgPhotonConv;
  logic [63:0] cfgMac;
  logic [31:0] cfgIpv4, cfgModules, cfgFrames, cfgSummation;
  logic [15:0] cfgCollId;

  int checks = 0, errors = 0;
  logic [31:0] expQ[$];
  string tagQ[$];

  always #5 clk = ~clk;

  accel_csr #(.ADDR_W(ADDR_W), .BASE(BASE)) dut_i (
    .clk(clk), .rstN(rstN),
    .axiAwValid(awValid), .axiAwReady(awReady), .axiAwAddr(awAddr),
    .axiWValid(wValid), .axiWReady(wReady), .axiWData(wData),
    .axiBValid(bValid), .axiBReady(bReady), .axiBResp(bResp),
    .axiArValid(arValid), .axiArReady(arReady), .axiArAddr(arAddr),
    .axiRValid(rValid), .axiRReady(rReady), .axiRData(rData), .axiRResp(rResp),
    .idleIn(idleIn), .evtIn(evtIn), .errIn(errIn),
    .actStart(actStart), .actCancel(actCancel), .clrNetCnt(clrNetCnt),
    .cfgMac(cfgMac), .cfgIpv4(cfgIpv4), .cfgModules(cfgModules), .cfgFrames(cfgFrames),
    .cfgSummation(cfgSummation), .cfgPhotonConv(cfgPhotonConv), .cfgCollId(cfgCollId)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as responses appear
  always @(negedge clk) begin
    if (rstN && rValid && rReady) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R1: unexpected read response actual 0x%0h expected none", rData);
      end else begin
        check(tagQ.pop_front(), rData, expQ.pop_front());
        check("R1 rresp", rResp, 2'b00);
      end
    end
  end

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    awValid = 1; wValid = 1; awAddr = a; wData = d;
    while (!awReady) @(negedge clk);
    @(negedge clk);
    awValid = 0; wValid = 0;
    check("R1 bvalid", bValid, 1'b1);
    check("R1 bresp", bResp, 2'b00);
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    arValid = 1; arAddr = a;
    while (!arReady) @(negedge clk);
    @(negedge clk);
    arValid = 0;
  endtask

  task automatic pulseEvt(input logic [6:0] v, input int n);
    @(negedge clk);
    evtIn = v;
    repeat (n) @(negedge clk);
    evtIn = '0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // reset state
    check("R2 reset cancel", actCancel, 1'b0);
    check("R7 reset modules", cfgModules, 32'd1);
    check("R7 reset summation", cfgSummation, 32'd1);
    rd(BASE + 'h00, 32'h2, "R2 reset ctrl");
    rd(BASE + 'h10, 32'h0, "R4 reset counter");
    // configuration
    wr(BASE + 'h80, 32'h33221100);
    wr(BASE + 'h84, 32'h00005544);
    wr(BASE + 'h88, 32'h0A01A8C0);
    wr(BASE + 'h94, 32'd100);
    check("R9 mac out", cfgMac, 64'h00005544_33221100);
    check("R9 frames out", cfgFrames, 32'd100);
    rd(BASE + 'h84, 32'h00005544, "R9 mac hi");
    rd(BASE + 'h88, 32'h0A01A8C0, "R9 ipv4");
    wr(BASE + 'h8C, 32'd3);
    check("R7 modules", cfgModules, 32'd4);
    rd(BASE + 'h8C, 32'd3, "R7 stored modules");
    wr(BASE + 'h98, 32'd0);
    check("R7 summation one", cfgSummation, 32'd1);
    wr(BASE + 'h90, 32'hABCD_FFFF);
    check("R8 collid", cfgCollId, 16'hABCD);
    check("R8 photon", cfgPhotonConv, 1'b1);
    rd(BASE + 'h90, 32'hABCD_0001, "R8 mode readback");
    // outside-window write ignored
    wr(20'h20088, 32'hDEADBEEF);
    check("R10 outside write", cfgIpv4, 32'h0A01A8C0);
    rd(20'h20088, 32'h0, "R10 outside read");
    rd(BASE + 'hA0, 32'h0, "R10 unmapped read");
    // counters
    pulseEvt(7'h7F, 5);
    pulseEvt(7'h01, 2);
    rd(BASE + 'h10, 32'd7, "R4 stall host");
    rd(BASE + 'h14, 32'd0, "R6 high word");
    rd(BASE + 'h20, 32'd5, "R4 action pkts");
    rd(BASE + 'h40, 32'd5, "R5 detector");
    wr(BASE + 'h28, 32'h77);
    rd(BASE + 'h28, 32'd5, "R10 read-only write");
    // cancel then start
    wr(BASE + 'h00, 32'h4);
    check("R2 cancel out", actCancel, 1'b1);
    rd(BASE + 'h00, 32'h6, "R2 ctrl cancel");
    wr(BASE + 'h00, 32'h5);
    check("R2 start pulse", actStart, 1'b1);
    check("R2 start clears cancel", actCancel, 1'b0);
    @(negedge clk);
    check("R2 pulse ends", actStart, 1'b0);
    rd(BASE + 'h10, 32'd0, "R4 stall host after start");
    rd(BASE + 'h18, 32'd0, "R4 stall mem after start");
    rd(BASE + 'h20, 32'd0, "R4 action pkts after start");
    rd(BASE + 'h28, 32'd5, "R5 eth after start");
    rd(BASE + 'h30, 32'd5, "R5 icmp after start");
    rd(BASE + 'h38, 32'd5, "R5 udp after start");
    // counter clear
    wr(BASE + 'h00, 32'h8);
    check("R2 clrnet out", clrNetCnt, 1'b1);
    rd(BASE + 'h28, 32'd0, "R5 eth cleared");
    rd(BASE + 'h40, 32'd0, "R5 detector cleared");
    rd(BASE + 'h00, 32'hA, "R2 ctrl clrnet");
    // errors
    @(negedge clk); errIn = 4'b0101;
    @(negedge clk); errIn = 4'b0000;
    rd(BASE + 'h00, 32'h0500_000A, "R3 err latch");
    @(negedge clk); errIn = 4'b1000;
    @(negedge clk); errIn = 4'b0000;
    rd(BASE + 'h00, 32'h0D00_000A, "R3 err accumulate");
    wr(BASE + 'h00, 32'h1);
    check("R2 start clears clrnet", clrNetCnt, 1'b0);
    rd(BASE + 'h00, 32'h3, "R3 err cleared by start");
    repeat (4) @(negedge clk);
    if (expQ.size() != 0) begin
      checks++; errors++;
      $display("FAIL R1: actual %0d pending expected 0", expQ.size());
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule